// File: doc/BRIEF.md
# ADC Peak Level Meter

This block watches a stream of signed converter samples and keeps the loudest level it has seen while metering is switched on. The level is held as a 6-bit attenuation code in 1 dB steps below full scale. Code 0 means full scale (0 dBFS), each step is 1 dB quieter, and code 63 means -63 dBFS or quieter. The code is on an output that a register read path samples. A read strobe tells the block that the value was taken, and the block then clears itself, so each read reports the peak since the previous read.

Each valid sample is first turned into a magnitude, with saturation of the most negative value. The magnitude is then compared in parallel against 63 constant thresholds, one for each dB step, which are computed at elaboration from the sample width. The number of thresholds the magnitude fails to reach is the sample's code. The held peak is the smallest code seen. A cleared meter holds code 63 ("no signal"), so any later sample can replace it. The register itself comes out of reset as 0.

A small state machine tracks whether metering is on and whether the meter holds a real sample. It has three states:
- `ST_OFF`: metering disabled, the value is held.
- `ST_EMPTY`: enabled and cleared, no sample taken yet.
- `ST_LIVE`: enabled and holding at least one sample.

It has six transitions:
- `OFF->EMPTY`: enable rises with no sample; the meter clears.
- `OFF->LIVE`: enable rises together with a sample.
- `EMPTY->LIVE`: a valid sample arrives.
- `LIVE->EMPTY`: a read arrives with no sample.
- `LIVE->LIVE`: a sample arrives, or nothing happens.
- `any->OFF`: enable goes low.

Top module: `adc_peak_meter`

## Requirements
- R1: After reset the peak code output is 0 (00h).
- R2: A sample's code is the smallest N in 0..62 for which its magnitude is at least 2^(DATA_W-1) x 10^(-(N+1)/20). A magnitude below every such threshold gives code 63, and a zero sample therefore gives 63.
- R3: The magnitude is the absolute value of the two's-complement sample. The most negative input saturates to 2^(DATA_W-1)-1, which gives code 0.
- R4: While enabled, each valid sample updates the held code to the smaller of the held code and the sample's code, one clock after the sample. A quieter sample leaves the held code unchanged.
- R5: A sample presented while enable is 0, or with valid at 0, has no effect on the held code.
- R6: On the first enabled cycle after enable was 0, the meter clears to 63. A valid sample in that same cycle is applied on top of the clear.
- R7: A read strobe clears the held code to 63 on the next clock, whether or not metering is enabled.
- R8: A valid enabled sample that arrives in the same cycle as a read is applied after the clear, so the next code is that sample's code.
- R9: While enable is 0, the state is ST_OFF and the held code is kept unchanged until a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_i | input | DATA_W | Signed two's-complement sample |
| smp_vld_i | input | 1 | Sample valid strobe |
| meter_en_i | input | 1 | Metering enable |
| peak_rd_i | input | 1 | Read strobe; clears the meter on the next clock |
| peak_code_o | output | 6 | Held peak as dB attenuation code (0 = 0 dBFS, 63 = -63 dBFS or lower) |

## Verification
The assertions assume that the enable, valid and read inputs are never unknown from reset on. They also assume that the sample word matters only in cycles where valid is high, because the code checks refer to the mapped sample code only under enable and valid. The stimulus drives every input to a defined value on the falling edge, holds it through the rising edge, and keeps the inputs at 0 during reset. Randomised patterns therefore always present clean strobes, including reads and enable edges that coincide with samples.

// File: rtl/adc_peak_meter_pkg.sv
package adc_peak_meter_pkg;
    localparam int CODE_W     = 6;
    localparam int NUM_STEPS  = 63;
    localparam logic [CODE_W-1:0] CODE_FLOOR = 6'd63;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_EMPTY = 2'd1,
        ST_LIVE  = 2'd2
    } pk_state_e;
endpackage

// File: rtl/pk_magnitude.sv
module pk_magnitude #(
    parameter int DATA_W = 24
) (
    input  logic [DATA_W-1:0] smp_i,
    output logic [DATA_W-1:0] mag_o
);
    localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] MOST_POS = {1'b0, {(DATA_W-1){1'b1}}};

    always_comb begin
        if (smp_i == MOST_NEG) begin
            mag_o = MOST_POS;
        end else if (smp_i[DATA_W-1]) begin
            mag_o = (~smp_i) + 1'b1;
        end else begin
            mag_o = smp_i;
        end
    end
endmodule

// File: rtl/pk_db_map.sv
module pk_db_map
    import adc_peak_meter_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic [DATA_W-1:0] mag_i,
    output logic [CODE_W-1:0] code_o
);
    localparam real FULL_SCALE = 2.0 ** (DATA_W - 1);

    logic [NUM_STEPS-1:0] below;

    for (genvar i = 0; i < NUM_STEPS; i++) begin : g_step
        localparam real THR_R = FULL_SCALE * (10.0 ** (-(real'(i) + 1.0) / 20.0));
        localparam logic [DATA_W-1:0] THR = DATA_W'($rtoi($ceil(THR_R)));
        assign below[i] = (mag_i < THR);
    end

    // thresholds fall with the index, so the fails form a thermometer
    always_comb begin
        code_o = '0;
        for (int k = 0; k < NUM_STEPS; k++) begin
            code_o = code_o + CODE_W'(below[k]);
        end
    end
endmodule

// File: rtl/pk_ctrl.sv
module pk_ctrl
    import adc_peak_meter_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              vld_i,
    input  logic              rd_i,
    input  logic [CODE_W-1:0] smp_code_i,
    output pk_state_e         state_o,
    output logic [CODE_W-1:0] peak_o
);
    pk_state_e         state_q, state_d;
    logic [CODE_W-1:0] peak_q, peak_d, base;
    logic              take;

    assign take = en_i && vld_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (en_i) state_d = take ? ST_LIVE : ST_EMPTY;
            end
            ST_EMPTY: begin
                if (!en_i)      state_d = ST_OFF;
                else if (take)  state_d = ST_LIVE;
            end
            ST_LIVE: begin
                if (!en_i)      state_d = ST_OFF;
                else if (take)  state_d = ST_LIVE;
                else if (rd_i)  state_d = ST_EMPTY;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        base = peak_q;
        if (rd_i || (state_q == ST_OFF && en_i)) base = CODE_FLOOR;
        peak_d = base;
        if (take && smp_code_i < base) peak_d = smp_code_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) peak_q <= '0;
        else        peak_q <= peak_d;
    end

    assign state_o = state_q;
    assign peak_o  = peak_q;
endmodule

// File: rtl/adc_peak_meter.sv
module adc_peak_meter
    import adc_peak_meter_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] smp_i,
    input  logic              smp_vld_i,
    input  logic              meter_en_i,
    input  logic              peak_rd_i,
    output logic [5:0]        peak_code_o
);
    logic [DATA_W-1:0] mag;
    logic [CODE_W-1:0] smp_code;
    pk_state_e         state;

    pk_magnitude #(.DATA_W(DATA_W)) u_mag (
        .smp_i (smp_i),
        .mag_o (mag)
    );

    pk_db_map #(.DATA_W(DATA_W)) u_map (
        .mag_i  (mag),
        .code_o (smp_code)
    );

    pk_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (meter_en_i),
        .vld_i      (smp_vld_i),
        .rd_i       (peak_rd_i),
        .smp_code_i (smp_code),
        .state_o    (state),
        .peak_o     (peak_code_o)
    );
endmodule

// File: rtl/adc_peak_meter_chk.sv
module adc_peak_meter_chk
    import adc_peak_meter_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              vld,
    input logic              rd,
    input logic [CODE_W-1:0] smp_code,
    input pk_state_e         state,
    input logic [5:0]        code
);
    AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !(en && vld)) |=> (code == CODE_FLOOR)); // R7

    AST_SAMPLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (en && vld) |=> (code <= $past(smp_code))); // R2

    AST_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !rd && state != ST_OFF) |=> (code <= $past(code))); // R4

    AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !rd) |=> $stable(code)); // R5

    AST_EN_RISE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && en && !vld) |=> (code == CODE_FLOOR)); // R6

    AST_OFF_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == ST_OFF)); // R9
endmodule

bind adc_peak_meter adc_peak_meter_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (meter_en_i),
    .vld      (smp_vld_i),
    .rd       (peak_rd_i),
    .smp_code (smp_code),
    .state    (state),
    .code     (peak_code_o)
);

// File: tb/adc_peak_meter_test.sv
module adc_peak_meter_test;
    localparam int  W          = 24;
    localparam time CLK_PERIOD = 10;
    localparam longint FS      = longint'(1) << (W - 1);

    typedef struct {
        int    exp;
        string tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] smp = '0;
    logic         vld = 1'b0, en = 1'b0, rd = 1'b0;
    logic [5:0]   code;

    int    n_checks = 0;
    int    n_fail   = 0;
    item_t sb[$];
    int    m_peak   = 0;
    bit    m_on     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_peak_meter #(.DATA_W(W)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_i       (smp),
        .smp_vld_i   (vld),
        .meter_en_i  (en),
        .peak_rd_i   (rd),
        .peak_code_o (code)
    );

    function automatic real thr(int n);
        return real'(FS) * (10.0 ** (-(real'(n) + 1.0) / 20.0));
    endfunction

    function automatic int code_of(logic [W-1:0] x);
        longint mag;
        mag = longint'($signed(x));
        if (mag < 0) mag = -mag;
        if (mag > FS - 1) mag = FS - 1;
        for (int n = 0; n < 63; n++) begin
            if (real'(mag) >= thr(n)) return n;
        end
        return 63;
    endfunction

    function automatic void check(int got, int exp, string tag);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s got %0d exp %0d", tag, got, exp);
        end
    endfunction

    // driver: presents one cycle of stimulus and pushes the expected code
    task automatic step(input longint x, input bit v, input bit e, input bit r, input string tag);
        int base;
        item_t it;
        @(negedge clk);
        smp = W'(x); vld = v; en = e; rd = r;
        base = (r || (!m_on && e)) ? 63 : m_peak;
        if (e && v && code_of(W'(x)) < base) base = code_of(W'(x));
        m_peak = base;
        m_on   = e;
        it.exp = base;
        it.tag = tag;
        sb.push_back(it);
    endtask

    // monitor: compares after each rising edge once registers settle
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(int'(code), it.exp, it.tag);
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired got 0 exp 1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(int'(code), 0, "R1");

        step(FS/2, 1, 0, 0, "R5");         // disabled sample ignored
        step(FS/2, 0, 1, 0, "R6");         // enable rise clears to 63
        step(FS/2, 0, 1, 0, "R5");         // valid low ignored
        step(FS/2, 1, 1, 0, "R2");         // half scale
        step(FS/64, 1, 1, 0, "R4");        // quieter keeps peak
        step(-8000000, 1, 1, 0, "R3");     // negative magnitude
        step(-FS, 1, 1, 0, "R3");          // most negative saturates
        step(0, 0, 1, 1, "R7");            // read clears
        step(0, 1, 1, 0, "R2");            // zero gives 63
        step(FS/8, 1, 1, 1, "R8");         // read plus sample
        step(FS - 1, 1, 0, 0, "R9");       // disabled: held
        step(0, 0, 0, 1, "R7");            // read while disabled
        step(FS/4, 1, 1, 0, "R6");         // enable rise with sample

        for (int k = 0; k < 63; k += 7) begin
            longint b;
            b = longint'($ceil(thr(k)));
            step(0, 0, 1, 1, "R7");
            step(b, 1, 1, 0, "R2");
            step(0, 0, 1, 1, "R7");
            step(b - 1, 1, 1, 0, "R2");
        end

        lfsr = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            longint x;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            x = longint'($signed(W'({lfsr, lfsr[7:0]}))) >>> lfsr[3:0];
            step(x, lfsr[0] | lfsr[5], lfsr[1] | lfsr[2] | lfsr[9], lfsr[4] & lfsr[6] & lfsr[8], "R4");
        end

        @(negedge clk);
        vld = 0; en = 0; rd = 0;
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule